// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block powers one switchable island up and down. A pulse on `req_on` starts the power-up sequence. The block closes the power switch at the gentlest inrush limit. If the synchronized power-good input does not appear within the dwell window, it raises the limit one code at a time. Once power is good, it releases electrical isolation and requests memory repair. When repair completes, it releases functional isolation and marks the island as up. A pulse on `req_off` shuts the island down in the reverse order. If power-good or repair-done never arrives, the block undoes the steps it has taken and raises a sticky error flag.

States: `S_IDLE` waits for a request. `S_RAMP` dwells at one inrush code. `S_LAST` makes one last power-good check after the highest code. `S_EISO` releases electrical isolation. `S_REPAIR` waits for repair-done. `S_FISO` releases functional isolation. `S_FAIL_E` and `S_FAIL_P` roll back after a failure. `S_DN_E` and `S_DN_P` handle shut-down. Transitions:
- IDLE→RAMP on a start request while the switch is open.
- IDLE→IDLE on a start request while the switch is already closed.
- IDLE→DN_E on a stop request.
- RAMP→EISO on power-good.
- RAMP→RAMP at the end of a window below the top code.
- RAMP→LAST at the end of the top code's window.
- LAST→EISO or LAST→FAIL_P.
- EISO→REPAIR.
- REPAIR→FISO on repair-done, or REPAIR→FAIL_E on timeout.
- FAIL_E→FAIL_P→IDLE.
- FISO→IDLE.
- DN_E→DN_P→IDLE.

Both dwell windows are given in nanoseconds and converted to clock cycles from `CLK_FREQ_HZ`: 150 cycles for power-good and 50 cycles for repair at 50 MHz.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset the state is idle, and every output and every bit of `status_word` is 0.
- R2: A start request with the switch open sets `sw_en` and `inrush_lim`=0 one cycle later. Without power-good, `inrush_lim` rises by one every PG_CYC cycles, up to 3, and never moves in any other way while the switch stays closed.
- R3: `pgood_async` passes through a two-flop synchronizer. Once it is seen, `eiso_rel` rises. One cycle later `mrep_req` rises. Each of these outputs changes on its own cycle.
- R4: When synchronized repair-done is seen, `mrep_req` falls. One cycle later `fiso_rel`, `done` and the island-up flag rise together.
- R5: A start request while `sw_en` is already 1 leaves every control output unchanged and sets `done` one cycle later.
- R6: If power-good is absent through all four windows and one final check, the block clears `sw_en` and `inrush_lim` and sets `err`.
- R7: If repair-done is absent for MR_CYC cycles, `mrep_req` falls. `eiso_rel` falls one cycle later, and `sw_en` and `inrush_lim` clear the cycle after that, with `err` set.
- R8: A stop request clears `fiso_rel` and the island-up flag. `eiso_rel` clears one cycle later, then `sw_en` and `inrush_lim` clear with `done` set.
- R9: `busy` is high outside idle. A request that arrives while busy is ignored. `done` and `err` clear when the next request is accepted and are never both 1.
- R10: `status_word` bit map: bit 0 switch enable; bit 1 synchronized power-good; bit 2 electrical isolation release; bit 3 memory-repair request; bit 4 synchronized repair-done; bit 5 functional isolation release; bit 8 busy; bit 9 done; bit 10 error; bit 12 island up; bits 14:13 inrush code (0=3.5 mA, 1=5 mA, 2=10 mA, 3=20 mA). All other bits are 0.
- R11: `fiso_rel` implies `eiso_rel`, `eiso_rel` implies `sw_en`, and `mrep_req` implies `eiso_rel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Shut-down request pulse (`req_on` wins if both are high) |
| pgood_async | input | 1 | Power-good from the switch, asynchronous |
| rdone_async | input | 1 | Repair-done from the repair engine, asynchronous |
| sw_en | output | 1 | Power switch enable |
| inrush_lim | output | 2 | Inrush current limit code |
| eiso_rel | output | 1 | Electrical isolation release |
| mrep_req | output | 1 | Memory repair request |
| fiso_rel | output | 1 | Functional isolation release |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky: last request completed |
| err | output | 1 | Sticky: last request timed out |
| status_word | output | 16 | Control and status read word |

## Verification
The assertions check the following on every cycle: the isolation interlock chain, the one-step-up-only inrush ramp, isolation being closed before the switch opens, the exclusive done and error flags, the no-change start while the switch is closed, and the bound on the dwell counter. Only the bench scenarios can show cycle-exact timing. This covers the window lengths, the synchronizer latency, the exact rollback order after each kind of timeout, and whether a request that arrives while busy is really dropped. For this, a behavioural model is compared against every output on every clock.

// File: rtl/pis_pkg.sv
package pis_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RAMP, S_LAST, S_EISO, S_REPAIR,
        S_FISO, S_FAIL_E, S_FAIL_P, S_DN_E, S_DN_P
    } seq_state_t;

    localparam int STW      = 16;
    localparam int B_SW     = 0;
    localparam int B_PGOOD  = 1;
    localparam int B_EISO   = 2;
    localparam int B_MREP   = 3;
    localparam int B_RDONE  = 4;
    localparam int B_FISO   = 5;
    localparam int B_BUSY   = 8;
    localparam int B_DONE   = 9;
    localparam int B_ERR    = 10;
    localparam int B_UP     = 12;
    localparam int B_INR_LO = 13;
    localparam logic [1:0] INR_TOP = 2'd3;
endpackage

// File: rtl/pis_sync.sv
module pis_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q_sync
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d_async[i];
                s2_q <= s1_q;
            end
        end
        assign q_sync[i] = s2_q;
    end
endmodule

// File: rtl/pis_win_timer.sv
module pis_win_timer #(
    parameter int PG_LIM = 150,
    parameter int MR_LIM = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sel_mr,
    output logic hit
);
    localparam int MAXLIM = (PG_LIM > MR_LIM) ? PG_LIM : MR_LIM;
    localparam int W      = $clog2(MAXLIM + 1);
    localparam logic [W-1:0] PG_END = W'(PG_LIM - 1);
    localparam logic [W-1:0] MR_END = W'(MR_LIM - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == (sel_mr ? MR_END : PG_END));

    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(MAXLIM));
endmodule

// File: rtl/pis_seq_fsm.sv
module pis_seq_fsm
    import pis_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_on,
    input  logic       req_off,
    input  logic       pg_s,
    input  logic       rd_s,
    input  logic       win_hit,
    output logic       win_clr,
    output logic       win_sel_mr,
    output logic       sw_q,
    output logic [1:0] inr_q,
    output logic       eiso_q,
    output logic       mrep_q,
    output logic       fiso_q,
    output logic       up_q,
    output logic       busy_o,
    output logic       done_q,
    output logic       err_q
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_on)       state_d = sw_q ? S_IDLE : S_RAMP;
                else if (req_off) state_d = S_DN_E;
            end
            S_RAMP: begin
                if (pg_s)                          state_d = S_EISO;
                else if (win_hit && inr_q == INR_TOP) state_d = S_LAST;
            end
            S_LAST:   state_d = pg_s ? S_EISO : S_FAIL_P;
            S_EISO:   state_d = S_REPAIR;
            S_REPAIR: begin
                if (rd_s)         state_d = S_FISO;
                else if (win_hit) state_d = S_FAIL_E;
            end
            S_FISO:   state_d = S_IDLE;
            S_FAIL_E: state_d = S_FAIL_P;
            S_FAIL_P: state_d = S_IDLE;
            S_DN_E:   state_d = S_DN_P;
            S_DN_P:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    assign win_clr    = !(((state_q == S_RAMP) && !win_hit) || (state_q == S_REPAIR));
    assign win_sel_mr = (state_q == S_REPAIR);
    assign busy_o     = (state_q != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q   <= 1'b0;
            inr_q  <= 2'd0;
            eiso_q <= 1'b0;
            mrep_q <= 1'b0;
            fiso_q <= 1'b0;
            up_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_on) begin
                        err_q  <= 1'b0;
                        done_q <= sw_q;
                        if (!sw_q) begin
                            sw_q  <= 1'b1;
                            inr_q <= 2'd0;
                        end
                    end else if (req_off) begin
                        err_q  <= 1'b0;
                        done_q <= 1'b0;
                        fiso_q <= 1'b0;
                        up_q   <= 1'b0;
                    end
                end
                S_RAMP: begin
                    if (pg_s)                             eiso_q <= 1'b1;
                    else if (win_hit && inr_q != INR_TOP) inr_q  <= inr_q + 2'd1;
                end
                S_LAST:   if (pg_s) eiso_q <= 1'b1;
                S_EISO:   mrep_q <= 1'b1;
                S_REPAIR: if (rd_s || win_hit) mrep_q <= 1'b0;
                S_FISO: begin
                    fiso_q <= 1'b1;
                    up_q   <= 1'b1;
                    done_q <= 1'b1;
                end
                S_FAIL_E: eiso_q <= 1'b0;
                S_FAIL_P: begin
                    sw_q  <= 1'b0;
                    inr_q <= 2'd0;
                    err_q <= 1'b1;
                end
                S_DN_E:   eiso_q <= 1'b0;
                S_DN_P: begin
                    sw_q   <= 1'b0;
                    inr_q  <= 2'd0;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_fiso_needs_eiso_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fiso_q |-> eiso_q);
    assert_eiso_needs_sw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eiso_q || mrep_q) |-> (sw_q && eiso_q == 1'b1 || !mrep_q && sw_q));
    assert_inrush_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q && $past(sw_q) && inr_q != $past(inr_q)) |-> (inr_q == $past(inr_q) + 2'd1));
    assert_iso_before_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_q) |-> (!$past(eiso_q) && !fiso_q));
    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));
    assert_on_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_on && sw_q) |=>
        (sw_q && $stable(inr_q) && $stable(eiso_q) && $stable(fiso_q) && done_q && !busy_o));
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_on || req_off));
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
    import pis_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int PG_WIN_NS   = 3000,
    parameter int MR_WIN_NS   = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_on,
    input  logic        req_off,
    input  logic        pgood_async,
    input  logic        rdone_async,
    output logic        sw_en,
    output logic [1:0]  inrush_lim,
    output logic        eiso_rel,
    output logic        mrep_req,
    output logic        fiso_rel,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] status_word
);
    localparam int KHZ     = CLK_FREQ_HZ / 1000;
    localparam int PG_RAW  = (KHZ * PG_WIN_NS) / 1_000_000;
    localparam int MR_RAW  = (KHZ * MR_WIN_NS) / 1_000_000;
    localparam int PG_CYC  = (PG_RAW < 2) ? 2 : PG_RAW;
    localparam int MR_CYC  = (MR_RAW < 2) ? 2 : MR_RAW;

    logic [1:0] sync_q;
    logic       win_clr, win_sel_mr, win_hit, up_q;

    pis_sync #(.N(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({rdone_async, pgood_async}),
        .q_sync(sync_q)
    );

    pis_win_timer #(.PG_LIM(PG_CYC), .MR_LIM(MR_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clr(win_clr), .sel_mr(win_sel_mr), .hit(win_hit)
    );

    pis_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_on(req_on), .req_off(req_off),
        .pg_s(sync_q[0]), .rd_s(sync_q[1]),
        .win_hit(win_hit), .win_clr(win_clr), .win_sel_mr(win_sel_mr),
        .sw_q(sw_en), .inr_q(inrush_lim), .eiso_q(eiso_rel),
        .mrep_q(mrep_req), .fiso_q(fiso_rel), .up_q(up_q),
        .busy_o(busy), .done_q(done), .err_q(err)
    );

    always_comb begin
        status_word                         = '0;
        status_word[B_SW]                   = sw_en;
        status_word[B_PGOOD]                = sync_q[0];
        status_word[B_EISO]                 = eiso_rel;
        status_word[B_MREP]                 = mrep_req;
        status_word[B_RDONE]                = sync_q[1];
        status_word[B_FISO]                 = fiso_rel;
        status_word[B_BUSY]                 = busy;
        status_word[B_DONE]                 = done;
        status_word[B_ERR]                  = err;
        status_word[B_UP]                   = up_q;
        status_word[B_INR_LO +: 2]          = inrush_lim;
    end

    assert_up_implies_fiso_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[B_UP] |-> fiso_rel);
endmodule

// File: tb/tb_pwr_island_seq.sv
module tb_pwr_island_seq;
    localparam int PG = (50_000 * 3000) / 1_000_000;
    localparam int MR = (50_000 * 1000) / 1_000_000;
    localparam int P_IDLE = 0, P_RAMP = 1, P_LAST = 2, P_EISO = 3, P_REP = 4,
                   P_FISO = 5, P_FE = 6, P_FP = 7, P_DE = 8, P_DP = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_on = 1'b0, req_off = 1'b0, pg_a = 1'b0, rd_a = 1'b0;
    logic sw_en, eiso_rel, mrep_req, fiso_rel, busy, done, err;
    logic [1:0] inrush_lim;
    logic [15:0] status_word;

    always #10 clk = ~clk;

    pwr_island_seq dut (
        .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
        .pgood_async(pg_a), .rdone_async(rd_a),
        .sw_en(sw_en), .inrush_lim(inrush_lim), .eiso_rel(eiso_rel),
        .mrep_req(mrep_req), .fiso_rel(fiso_rel), .busy(busy),
        .done(done), .err(err), .status_word(status_word)
    );

    int compared = 0, mismatched = 0;
    string cur_req = "R1";
    bit finished = 0;

    int ph = P_IDLE, cnt = 0, m_inr = 0;
    bit m_sw = 0, m_e = 0, m_m = 0, m_f = 0, m_up = 0, m_done = 0, m_err = 0;
    bit p1 = 0, p2 = 0, r1 = 0, r2 = 0;

    function automatic logic [15:0] m_status();
        logic [15:0] w = '0;
        w[0] = m_sw; w[1] = p2; w[2] = m_e; w[3] = m_m; w[4] = r2; w[5] = m_f;
        w[8] = (ph != P_IDLE); w[9] = m_done; w[10] = m_err; w[12] = m_up;
        w[14:13] = 2'(m_inr);
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = P_IDLE; cnt = 0; m_inr = 0; m_sw = 0; m_e = 0; m_m = 0; m_f = 0;
            m_up = 0; m_done = 0; m_err = 0; p1 = 0; p2 = 0; r1 = 0; r2 = 0;
        end else begin
            bit hit;
            int nph;
            hit = (cnt == ((ph == P_REP) ? MR - 1 : PG - 1));
            nph = ph;
            case (ph)
                P_IDLE: if (req_on) begin
                    m_err = 0; m_done = m_sw;
                    if (!m_sw) begin m_sw = 1; m_inr = 0; nph = P_RAMP; end
                end else if (req_off) begin
                    m_err = 0; m_done = 0; m_f = 0; m_up = 0; nph = P_DE;
                end
                P_RAMP: if (p2) begin m_e = 1; nph = P_EISO; end
                        else if (hit) begin
                            if (m_inr == 3) nph = P_LAST; else m_inr++;
                        end
                P_LAST: if (p2) begin m_e = 1; nph = P_EISO; end else nph = P_FP;
                P_EISO: begin m_m = 1; nph = P_REP; end
                P_REP:  if (r2) begin m_m = 0; nph = P_FISO; end
                        else if (hit) begin m_m = 0; nph = P_FE; end
                P_FISO: begin m_f = 1; m_up = 1; m_done = 1; nph = P_IDLE; end
                P_FE:   begin m_e = 0; nph = P_FP; end
                P_FP:   begin m_sw = 0; m_inr = 0; m_err = 1; nph = P_IDLE; end
                P_DE:   begin m_e = 0; nph = P_DP; end
                P_DP:   begin m_sw = 0; m_inr = 0; m_done = 1; nph = P_IDLE; end
                default: nph = P_IDLE;
            endcase
            cnt = (((ph == P_RAMP) && !hit) || (ph == P_REP)) ? cnt + 1 : 0;
            ph = nph;
            p2 = p1; p1 = pg_a; r2 = r1; r1 = rd_a;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !finished)
        check(cur_req, {16'h0, status_word},
              {16'h0, m_status()} & 32'hFFFF | {31'h0, 1'b0});

    always @(negedge clk) if (rst_n && !finished) begin
        logic [7:0] act, exp;
        act = {sw_en, inrush_lim, eiso_rel, mrep_req, fiso_rel, done, err};
        exp = {m_sw, 2'(m_inr), m_e, m_m, m_f, m_done, m_err};
        check({cur_req, "_pins"}, {24'h0, act}, {24'h0, exp});
    end

    task automatic pulse_on();
        @(negedge clk) req_on = 1'b1;
        @(negedge clk) req_on = 1'b0;
    endtask
    task automatic pulse_off();
        @(negedge clk) req_off = 1'b1;
        @(negedge clk) req_off = 1'b0;
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1_reset", {16'h0, status_word}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1_idle", {31'h0, busy}, 32'h0);

        // R2 R3 R4: ramp to code 1, then power-good, repair-done
        cur_req = "R2";
        pulse_on();
        check("R2_start", {29'h0, sw_en, inrush_lim}, {29'h0, 1'b1, 2'd0});
        for (int i = 0; i < 400 && inrush_lim != 2'd1; i++) @(negedge clk);
        check("R2_step", {30'h0, inrush_lim}, 32'd1);
        cur_req = "R3";
        pg_a = 1'b1;
        for (int i = 0; i < 50 && !mrep_req; i++) @(negedge clk);
        check("R3_mrep", {30'h0, eiso_rel, mrep_req}, 32'd3);
        repeat (8) @(negedge clk);
        cur_req = "R4";
        rd_a = 1'b1;
        wait_idle();
        check("R4_up", {29'h0, fiso_rel, done, err}, 32'b110);
        cur_req = "R10";
        check("R10_map", {16'h0, status_word}, 32'h3237);
        rd_a = 1'b0;
        repeat (3) @(negedge clk);

        // R5: start while already on
        cur_req = "R5";
        pulse_on();
        check("R5_noop", {28'h0, sw_en, fiso_rel, done, busy}, 32'b1110);

        // R8: shut-down order
        cur_req = "R8";
        pulse_off();
        check("R8_fiso", {29'h0, sw_en, eiso_rel, fiso_rel}, 32'b110);
        @(negedge clk);
        check("R8_eiso", {30'h0, sw_en, eiso_rel}, 32'b10);
        @(negedge clk);
        check("R8_sw", {29'h0, sw_en, done, busy}, 32'b010);
        pg_a = 1'b0;
        repeat (4) @(negedge clk);

        // R6: power-good never arrives
        cur_req = "R6";
        pulse_on();
        wait_idle();
        check("R6_fail", {28'h0, sw_en, inrush_lim, err}, 32'b0001);

        // R7: repair-done never arrives
        cur_req = "R7";
        pg_a = 1'b1;
        repeat (3) @(negedge clk);
        pulse_on();
        check("R7_err_clr", {31'h0, err}, 32'h0);
        wait_idle();
        check("R7_fail", {28'h0, sw_en, eiso_rel, mrep_req, err}, 32'b0001);

        // R9: request while busy ignored
        cur_req = "R9";
        rd_a = 1'b1;
        @(negedge clk) req_on = 1'b1;
        @(negedge clk) begin req_on = 1'b0; req_off = 1'b1; end
        @(negedge clk) req_off = 1'b0;
        check("R9_busy", {30'h0, busy, err}, 32'b10);
        wait_idle();
        check("R9_done", {29'h0, fiso_rel, done, err}, 32'b110);
        pulse_off();
        check("R9_done_clr", {31'h0, done}, 32'h0);
        wait_idle();
        pg_a = 1'b0; rd_a = 1'b0;
        repeat (4) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule